// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the setting of one memory-protection entry into an inclusive byte-address window, given as a lowest and a highest byte address. Its inputs are the entry's two-bit matching mode, its word-granular address register and the address register of the entry just below it. A later stage can then test any access address with two plain magnitude compares, and never has to decode the mode again.

Each entry's address register holds a byte address shifted right by two, so the byte-address outputs are two bits wider than the register. The decode is combinational. It is captured into output registers on a cycle in which the update strobe is high. The outputs change on the next clock edge and keep their value until the next update.

Top module: `pmp_region_bounds`

## Requirements
- R1: While reset is high at a clock edge, the outputs become the disabled window: lowest address 0 and highest address all ones.
- R2: The outputs take the decode of the inputs present at a rising edge where `upd` is high, and they are visible after that edge. With `upd` low, input changes have no effect on the outputs.
- R3: Mode value 0 (disabled) yields lowest address 0 and highest address all ones, whatever the address inputs hold.
- R4: Mode value 1 (top-of-range) yields lowest = `prev_addr` shifted left by 2 and highest = (`cur_addr` shifted left by 2) minus 1, modulo 2^(AW+2), so `cur_addr` = 0 gives all ones.
- R5: In mode value 1 with `entry_zero` high, the lowest address is 0 whatever `prev_addr` holds.
- R6: Mode value 2 (single word) yields the 4 bytes from `cur_addr` shifted left by 2 through that value plus 3.
- R7: Mode value 3 (naturally aligned power of two): with t the count of consecutive ones from bit 0 of `cur_addr`, the lowest address is `cur_addr` with bits t-1..0 cleared and then shifted left by 2, and the highest address is the lowest plus 2^(t+3) minus 1.
- R8: In mode value 3 a `cur_addr` of all ones, and also one whose only zero is the top bit, decode to the full window 0 through all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Capture the decode of the present inputs |
| mode | input | 2 | Matching mode: 0 disabled, 1 top-of-range, 2 single word, 3 power-of-two |
| cur_addr | input | AW | This entry's address register (byte address >> 2) |
| prev_addr | input | AW | Address register of the entry below |
| entry_zero | input | 1 | High when this is the lowest entry, which has no neighbour below |
| rgn_lo | output | AW+2 | Inclusive lowest byte address of the window |
| rgn_hi | output | AW+2 | Inclusive highest byte address of the window |

## Verification
A fault in the trailing-ones run shows on the port as a power-of-two window of the wrong size or with the wrong alignment. A fault in the output registers shows as bounds that follow the inputs while `upd` is low, or that arrive a cycle late. Either error is visible on the first edge after the update that exposes it. For this reason the checks sample one cycle after each update and again after idle cycles with the inputs disturbed. The naturally aligned cases cover run lengths of 0, 1, 12 and 31 bits, a register of all ones, and a top bit set above a zero run, so that a fault in the trailing-ones run does not go unseen.

// File: rtl/pmpb_pkg.sv
package pmpb_pkg;
  typedef enum logic [1:0] {
    RGN_OFF   = 2'd0,
    RGN_TOR   = 2'd1,
    RGN_NA4   = 2'd2,
    RGN_NAPOT = 2'd3
  } rgn_mode_e;
endpackage

// File: rtl/pmpb_trail_ones.sv
module pmpb_trail_ones #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  output logic [W-1:0]  run,
  output logic [CW-1:0] count,
  output logic          all_ones
);
  // run[i] is set when bits i..0 of word are all ones
  assign run[0] = word[0];
  generate
    for (genvar i = 1; i < W; i++) begin : g_run
      assign run[i] = run[i-1] & word[i];
    end
  endgenerate

  assign all_ones = run[W-1];

  // priority encoder: index of the lowest zero bit
  always_comb begin
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!word[i]) count = CW'(i);
    end
  end

  always_comb begin
    if (!$isunknown(word)) begin
      // R7
      run_count_chk: assert ($countones(run) == int'(count));
    end
  end
endmodule

// File: rtl/pmpb_decode.sv
module pmpb_decode #(
  parameter int AW = 32,
  localparam int BW = AW + 2
) (
  input  pmpb_pkg::rgn_mode_e mode,
  input  logic [AW-1:0]       cur_addr,
  input  logic [AW-1:0]       prev_addr,
  input  logic                entry_zero,
  output logic [BW-1:0]       lo,
  output logic [BW-1:0]       hi
);
  import pmpb_pkg::*;
  localparam int CW = $clog2(AW + 1);

  logic [AW-1:0] run;
  logic [CW-1:0] ones_cnt;
  logic          full;
  logic [BW-1:0] napot_base;
  logic [BW-1:0] napot_mask;
  logic [BW-1:0] span;

  pmpb_trail_ones #(.W(AW), .CW(CW)) u_trail (
    .word     (cur_addr),
    .run      (run),
    .count    (ones_cnt),
    .all_ones (full)
  );

  // base has bits t+2..0 clear, so OR with t+3 low ones gives the end
  assign napot_base = {cur_addr & ~run, 2'b00};
  assign napot_mask = {run[AW-2:0], 3'b111};

  always_comb begin
    lo = '0;
    hi = '1;
    unique case (mode)
      RGN_OFF: begin
        lo = '0;
        hi = '1;
      end
      RGN_TOR: begin
        lo = entry_zero ? '0 : {prev_addr, 2'b00};
        hi = {cur_addr, 2'b00} - BW'(1);
      end
      RGN_NA4: begin
        lo = {cur_addr, 2'b00};
        hi = {cur_addr, 2'b11};
      end
      RGN_NAPOT: begin
        if (full) begin
          lo = '0;
          hi = '1;
        end else begin
          lo = napot_base;
          hi = napot_base | napot_mask;
        end
      end
      default: begin
        lo = '0;
        hi = '0;
      end
    endcase
  end

  assign span = hi ^ lo;

  always_comb begin
    if (mode == RGN_NAPOT && !$isunknown(cur_addr)) begin
      // R7
      napot_align_chk: assert (((lo & span) == '0) && (((span + BW'(1)) & span) == '0));
    end
  end
endmodule

// File: rtl/pmp_region_bounds.sv
module pmp_region_bounds #(
  parameter int AW = 32,
  localparam int BW = AW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] prev_addr,
  input  logic          entry_zero,
  output logic [BW-1:0] rgn_lo,
  output logic [BW-1:0] rgn_hi
);
  import pmpb_pkg::*;

  rgn_mode_e     mode_e;
  logic [BW-1:0] dec_lo;
  logic [BW-1:0] dec_hi;

  assign mode_e = rgn_mode_e'(mode);

  pmpb_decode #(.AW(AW)) u_dec (
    .mode       (mode_e),
    .cur_addr   (cur_addr),
    .prev_addr  (prev_addr),
    .entry_zero (entry_zero),
    .lo         (dec_lo),
    .hi         (dec_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rgn_lo <= '0;
      rgn_hi <= '1;
    end else if (upd) begin
      rgn_lo <= dec_lo;
      rgn_hi <= dec_hi;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(rgn_lo) && $stable(rgn_hi)));

  // R3
  off_window_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 2'd0) |=> (rgn_lo == '0 && rgn_hi == '1));

  // R5
  tor_first_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 2'd1 && entry_zero) |=> (rgn_lo == '0));

  // R6
  word_size_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 2'd2) |=> ((rgn_hi - rgn_lo) == BW'(3)));

  // R8
  napot_full_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == 2'd3 && cur_addr[AW-2:0] == '1) |=> (rgn_lo == '0 && rgn_hi == '1));
endmodule

// File: tb/pmp_region_bounds_bench.sv
module pmp_region_bounds_bench;
  localparam int AW = 32;
  localparam int BW = AW + 2;
  localparam int N  = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [AW-1:0] cur_addr = '0;
  logic [AW-1:0] prev_addr = '0;
  logic          entry_zero = 1'b0;
  logic [BW-1:0] rgn_lo;
  logic [BW-1:0] rgn_hi;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pmp_region_bounds #(.AW(AW)) u_pmp_region_bounds (
    .clk(clk), .rst(rst), .upd(upd), .mode(mode),
    .cur_addr(cur_addr), .prev_addr(prev_addr), .entry_zero(entry_zero),
    .rgn_lo(rgn_lo), .rgn_hi(rgn_hi)
  );

  localparam logic [1:0]    T_MODE [N] = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2,
                                           2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
  localparam logic [AW-1:0] T_CUR  [N] = '{32'h1234_5678, 32'h0000_0200, 32'h0000_0000,
                                           32'h0000_0200, 32'h0000_1000, 32'hFFFF_FFFF,
                                           32'h0000_1000, 32'h0000_1001, 32'h0000_2FFF,
                                           32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005,
                                           32'h8000_0000};
  localparam logic [AW-1:0] T_PREV [N] = '{32'h0000_0040, 32'h0000_0100, 32'h0000_0010,
                                           32'h0000_0100, 32'h0, 32'h0, 32'h0, 32'h0,
                                           32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic          T_EZ   [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                                           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [BW-1:0] T_LO   [N] = '{34'h0, 34'h400, 34'h40, 34'h0, 34'h4000,
                                           34'h3_FFFF_FFFC, 34'h4000, 34'h4000, 34'h8000,
                                           34'h0, 34'h0, 34'h10, 34'h2_0000_0000};
  localparam logic [BW-1:0] T_HI   [N] = '{34'h3_FFFF_FFFF, 34'h7FF, 34'h3_FFFF_FFFF,
                                           34'h7FF, 34'h4003, 34'h3_FFFF_FFFF, 34'h4007,
                                           34'h400F, 34'hFFFF, 34'h3_FFFF_FFFF,
                                           34'h3_FFFF_FFFF, 34'h1F, 34'h2_0000_0007};
  // rows: R3 | R4 x2 | R5 | R6 x2 | R7 x3 | R8 x2 | R7 x2
  localparam logic [15:0]   T_REQ  [N] = '{"R3", "R4", "R4", "R5", "R6", "R6", "R7",
                                           "R7", "R7", "R8", "R8", "R7", "R7"};

  task automatic chk(input logic [15:0] req, input logic [BW-1:0] lo_exp,
                     input logic [BW-1:0] hi_exp);
    checks++;
    if (rgn_lo !== lo_exp || rgn_hi !== hi_exp) begin
      errors++;
      $display("FAIL %s lo=%h exp %h hi=%h exp %h", req, rgn_lo, lo_exp, rgn_hi, hi_exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [AW-1:0] c,
                       input logic [AW-1:0] p, input logic ez);
    @(negedge clk);
    mode = m; cur_addr = c; prev_addr = p; entry_zero = ez; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", '0, '1);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      apply(T_MODE[i], T_CUR[i], T_PREV[i], T_EZ[i]);
      chk(T_REQ[i], T_LO[i], T_HI[i]);
    end

    // R2: idle cycles with disturbed inputs keep the last window
    mode = 2'd2; cur_addr = 32'h55; prev_addr = 32'h99; entry_zero = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", 34'h2_0000_0000, 34'h2_0000_0007);

    // R2: the new window is not visible before the capturing edge
    @(negedge clk);
    mode = 2'd1; cur_addr = 32'h30; prev_addr = 32'h20; entry_zero = 1'b0; upd = 1'b1;
    #1 chk("R2", 34'h2_0000_0000, 34'h2_0000_0007);
    @(negedge clk);
    upd = 1'b0;
    chk("R4", 34'h80, 34'hBF);

    // R5: a large previous register is still ignored for the lowest entry
    apply(2'd1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1);
    chk("R5", 34'h0, 34'h3);

    // R3: disabled mode with extreme address inputs
    apply(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk("R3", '0, '1);

    // R1: reset in mid-run restores the disabled window
    apply(2'd2, 32'h0000_0010, 32'h0, 1'b0);
    chk("R6", 34'h40, 34'h43);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", '0, '1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule